// File: doc/BRIEF.md
# Banked Configuration Register Target over SPI

This block is a serial configuration target for a larger chip. A host reaches it over a four-wire SPI link in mode 0. Each transaction is a fixed 24-bit word: a leading opcode or register-address byte, then a 16-bit payload. Behind the link are three banks of 16-bit configuration registers: a common bank, a current-channel bank and a voltage-channel bank. Their contents drive the rest of the chip through a flat configuration bus.

A one-hot bank-select register decides which bank register accesses reach. Reads are pipelined. A read request is decoded at the end of the frame that carries it. Its data is then shifted out during the next frame, in the top 16 bits, with a zero low byte. A run of reads therefore returns, in each frame, the data asked for by the frame before it. An all-zero frame drains the last result.

SCLK, chip select and MOSI are sampled by the block's own clock through two-stage synchronizers, and the SCLK edges are detected in that clock domain. The host's SCLK must therefore run well below the system clock.

Top module: `spi_bank_regs`

## Requirements
- R1: A frame is 24 bits, most significant bit first. MOSI is taken on SCLK rising edges. MISO moves only on SCLK falling edges or when chip select changes, and its first bit is valid after chip select falls and before the first rising edge. MISO reads 0 while chip select is high.
- R2: If chip select rises before the 24th rising edge, the frame is dropped. No register changes, and the pending read result is kept for the next full frame.
- R3: A frame whose opcode byte [23:16] is 0x02 writes the bank select. Payload 0x0001 selects the common bank, 0x0002 the current bank and 0x0004 the voltage bank. Any other payload is ignored. A read of address 0x02 returns the current select code.
- R4: A frame whose opcode byte is neither 0x00, 0x01 nor 0x02 writes its payload to that address in the selected bank only. Bank registers sit at addresses 0x10 to 0x13, and bank b register i appears on cfg_o bits [(b*4+i)*16 +: 16].
- R5: A read is opcode 0x01, with the address in bits [15:8] and 0x01 in bits [7:0]. Its data appears in the next frame on MISO bits [23:8], and bits [7:0] are 0x00.
- R6: Every complete frame that is not a read makes the next frame shift out all zeros. This includes a bank select, a write, and an opcode 0x01 frame whose low byte is not 0x01. As a result, the first read after a bank select returns zeros.
- R7: In a run of back-to-back reads, each frame returns the data of the address sent in the previous frame.
- R8: An all-zero frame returns the result of the previous read and performs no access.
- R9: Writes to addresses outside 0x02 and 0x10 to 0x13 change nothing. Reads of any address other than 0x02 and 0x10 to 0x13 return zero.
- R10: After reset, the bank select is 0x0001, and bank b register i holds 0x1000*(b+1)+i. The first frame shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| cfg_o | output | 192 | All bank registers, bank-major, 16 bits each |

## Verification
Several properties are checked on every cycle. The bank select always holds exactly one bit and changes only on a completed frame. A completed non-read frame always empties the response. A write outside the register window never moves the configuration bus. MISO never changes except on an SCLK falling edge or a chip-select change. The bench scenarios cover what needs a frame-level view. These are the one-frame read delay, pipelined runs across a bank change, aborted frames that keep the pending result, and the values restored by a reset in the middle of a sequence.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  localparam int FRAME_W       = 24;
  localparam int DATA_W        = 16;
  localparam int ADDR_W        = 8;
  localparam int NUM_BANKS     = 3;
  localparam int REGS_PER_BANK = 4;

  localparam logic [ADDR_W-1:0] OP_NOP       = 8'h00;
  localparam logic [ADDR_W-1:0] OP_READ      = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_BANKSEL = 8'h02;
  localparam logic [ADDR_W-1:0] READ_TAG     = 8'h01;
  localparam logic [ADDR_W-1:0] REG_BASE     = 8'h10;

  // Decoded view of one completed frame
  typedef struct packed {
    logic              commit;
    logic              rd_req;
    logic              sel_wr;
    logic              reg_wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [DATA_W-1:0] reg_default(input int bank, input int idx);
    return DATA_W'((bank + 1) * 4096 + idx);
  endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_bank_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          cs_n_i,
  input  logic          mosi_i,
  input  logic [FW-1:0] tx_word_i,
  output logic          frame_vld_o,
  output logic [FW-1:0] frame_o,
  output logic          miso_o,
  output logic          tx_evt_o
);

  localparam int CW = $clog2(FW + 1);

  logic [1:0]    sclk_meta_q, cs_meta_q, mosi_meta_q;
  logic          sclk_d_q, cs_d_q;
  logic          sclk_s, cs_s, mosi_s;
  logic          sclk_rise, sclk_fall, cs_start, cs_stop;

  logic [FW-1:0] rx_q, rx_n;
  logic [FW-1:0] tx_q, tx_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          vld_q, vld_n;

  // Pin synchronizers and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_meta_q <= 2'b00;
      cs_meta_q   <= 2'b11;
      mosi_meta_q <= 2'b00;
      sclk_d_q    <= 1'b0;
      cs_d_q      <= 1'b1;
    end else begin
      sclk_meta_q <= {sclk_meta_q[0], sclk_i};
      cs_meta_q   <= {cs_meta_q[0], cs_n_i};
      mosi_meta_q <= {mosi_meta_q[0], mosi_i};
      sclk_d_q    <= sclk_meta_q[1];
      cs_d_q      <= cs_meta_q[1];
    end
  end

  assign sclk_s    = sclk_meta_q[1];
  assign cs_s      = cs_meta_q[1];
  assign mosi_s    = mosi_meta_q[1];
  assign sclk_rise = sclk_s & ~sclk_d_q & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d_q & ~cs_s;
  assign cs_start  = ~cs_s & cs_d_q;
  assign cs_stop   = cs_s & ~cs_d_q;

  always_comb begin
    rx_n  = rx_q;
    tx_n  = tx_q;
    cnt_n = cnt_q;
    vld_n = 1'b0;
    if (cs_s) begin
      cnt_n = '0;
      tx_n  = '0;
    end else if (cs_start) begin
      cnt_n = '0;
      tx_n  = tx_word_i;
    end else begin
      if (sclk_rise && (cnt_q < CW'(FW))) begin
        rx_n  = {rx_q[FW-2:0], mosi_s};
        cnt_n = cnt_q + 1'b1;
        vld_n = (cnt_q == CW'(FW - 1));
      end
      if (sclk_fall) begin
        tx_n = {tx_q[FW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      cnt_q <= cnt_n;
      vld_q <= vld_n;
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = rx_q;
  assign miso_o      = tx_q[FW-1];
  assign tx_evt_o    = sclk_fall | cs_start | cs_stop;

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_bank_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output cmd_t               cmd_o
);

  logic [ADDR_W-1:0] op;
  logic [DATA_W-1:0] payload;
  logic              code_ok;

  assign op      = frame_i[FRAME_W-1:DATA_W];
  assign payload = frame_i[DATA_W-1:0];
  assign code_ok = ($countones(payload) == 1) && ((payload >> NB) == '0);

  always_comb begin
    cmd_o        = '0;
    cmd_o.commit = frame_vld_i;
    cmd_o.rd_req = frame_vld_i && (op == OP_READ) && (payload[ADDR_W-1:0] == READ_TAG);
    cmd_o.sel_wr = frame_vld_i && (op == ADDR_BANKSEL) && code_ok;
    cmd_o.reg_wr = frame_vld_i && (op != OP_NOP) && (op != OP_READ) && (op != ADDR_BANKSEL);
    cmd_o.addr   = (op == OP_READ) ? payload[DATA_W-1:ADDR_W] : op;
    cmd_o.data   = payload;
  end

endmodule

// File: rtl/spi_bank_array.sv
module spi_bank_array
  import spi_bank_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int NR = REGS_PER_BANK,
  parameter int DW = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB-1:0]       bank_sel_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [NB*NR*DW-1:0] cfg_o
);

  logic [NB*NR*DW-1:0] cfg_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar i = 0; i < NR; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] RADDR = ADDR_W'(int'(REG_BASE) + i);
      logic [DW-1:0] val_q, val_n;
      logic          wr_hit;

      assign wr_hit = wr_en_i && bank_sel_i[b] && (addr_i == RADDR);

      always_comb begin
        val_n = val_q;
        if (wr_hit) val_n = wr_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= reg_default(b, i);
        else        val_q <= val_n;
      end

      assign cfg_flat[(b*NR+i)*DW +: DW] = val_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NR; i++) begin
        if (bank_sel_i[b] && (addr_i == ADDR_W'(int'(REG_BASE) + i)))
          rd_data_o = rd_data_o | cfg_flat[(b*NR+i)*DW +: DW];
      end
    end
  end

  assign cfg_o = cfg_flat;

endmodule

// File: rtl/spi_bank_regs.sv
module spi_bank_regs
  import spi_bank_pkg::*;
#(
  parameter int NUM_B = NUM_BANKS,
  parameter int NUM_R = REGS_PER_BANK
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         cs_n,
  input  logic                         mosi,
  output logic                         miso,
  output logic [NUM_B*NUM_R*DATA_W-1:0] cfg_o
);

  localparam int PAD_W = FRAME_W - DATA_W;

  logic               frm_vld;
  logic [FRAME_W-1:0] frm_word;
  logic [FRAME_W-1:0] tx_word;
  logic               tx_evt;
  cmd_t               cmd;

  logic [NUM_B-1:0]   bank_sel_q, bank_sel_n;
  logic [DATA_W-1:0]  resp_q, resp_n;
  logic [DATA_W-1:0]  arr_rd;
  logic [DATA_W-1:0]  rd_mux;

  spi_frame_shifter #(.FW(FRAME_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk),
    .cs_n_i      (cs_n),
    .mosi_i      (mosi),
    .tx_word_i   (tx_word),
    .frame_vld_o (frm_vld),
    .frame_o     (frm_word),
    .miso_o      (miso),
    .tx_evt_o    (tx_evt)
  );

  spi_cmd_decode #(.NB(NUM_B)) u_dec (
    .frame_vld_i (frm_vld),
    .frame_i     (frm_word),
    .cmd_o       (cmd)
  );

  spi_bank_array #(.NB(NUM_B), .NR(NUM_R), .DW(DATA_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel_i(bank_sel_q),
    .wr_en_i   (cmd.reg_wr),
    .addr_i    (cmd.addr),
    .wr_data_i (cmd.data),
    .rd_data_o (arr_rd),
    .cfg_o     (cfg_o)
  );

  assign rd_mux = (cmd.addr == ADDR_BANKSEL) ? DATA_W'(bank_sel_q) : arr_rd;

  always_comb begin
    bank_sel_n = bank_sel_q;
    resp_n     = resp_q;
    if (cmd.sel_wr) bank_sel_n = cmd.data[NUM_B-1:0];
    if (cmd.commit) resp_n = cmd.rd_req ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel_q <= NUM_B'(1);
      resp_q     <= '0;
    end else begin
      bank_sel_q <= bank_sel_n;
      resp_q     <= resp_n;
    end
  end

  assign tx_word = {resp_q, {PAD_W{1'b0}}};

endmodule

// File: rtl/spi_bank_regs_chk.sv
module spi_bank_regs_chk
  import spi_bank_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int NR = REGS_PER_BANK
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NB-1:0]          bank_sel,
  input logic                   commit,
  input logic                   rd_req,
  input logic                   reg_wr,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      resp,
  input logic [NB*NR*DATA_W-1:0] cfg,
  input logic                   tx_evt,
  input logic                   miso
);

  logic undef_wr;
  assign undef_wr = reg_wr && ((int'(wr_addr) < int'(REG_BASE)) ||
                               (int'(wr_addr) >= int'(REG_BASE) + NR));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_sel) == 1);

  // R3
  sel_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank_sel));

  // R6
  nonread_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rd_req) |=> (resp == '0));

  // R9
  undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_wr |=> $stable(cfg));

  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_evt |=> $stable(miso));

endmodule

bind spi_bank_regs spi_bank_regs_chk #(.NB(NUM_B), .NR(NUM_R)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bank_sel(bank_sel_q),
  .commit  (cmd.commit),
  .rd_req  (cmd.rd_req),
  .reg_wr  (cmd.reg_wr),
  .wr_addr (cmd.addr),
  .resp    (resp_q),
  .cfg     (cfg_o),
  .tx_evt  (tx_evt),
  .miso    (miso)
);

// File: tb/spi_bank_regs_test.sv
`timescale 1ns/1ps
module spi_bank_regs_test;

  localparam int HALF = 8;   // clk cycles per SCLK half period
  localparam int CFGW = 3*4*16;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi, miso;
  logic [CFGW-1:0] cfg_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  spi_bank_regs uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .cfg_o(cfg_o)
  );

  // Behavioural reference model
  logic [15:0] m_reg [3][4];
  logic [2:0]  m_sel;
  logic [23:0] m_pend;

  task automatic m_reset();
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 4; i++)
        m_reg[b][i] = 16'((b + 1) * 4096 + i);
    m_sel  = 3'b001;
    m_pend = '0;
  endtask

  function automatic logic [15:0] m_read(input logic [7:0] a);
    if (a == 8'h02) return {13'b0, m_sel};
    if (a >= 8'h10 && a < 8'h14)
      for (int b = 0; b < 3; b++)
        if (m_sel[b]) return m_reg[b][a - 8'h10];
    return 16'h0000;
  endfunction

  task automatic m_apply(input logic [23:0] w);
    logic [7:0] op;
    op = w[23:16];
    if (op == 8'h01 && w[7:0] == 8'h01) begin
      m_pend = {m_read(w[15:8]), 8'h00};
    end else begin
      m_pend = '0;
      if (op == 8'h02) begin
        if (w[15:0] == 16'h1 || w[15:0] == 16'h2 || w[15:0] == 16'h4) m_sel = w[2:0];
      end else if (op >= 8'h10 && op < 8'h14) begin
        for (int b = 0; b < 3; b++)
          if (m_sel[b]) m_reg[b][op - 8'h10] = w[15:0];
      end
    end
  endtask

  function automatic logic [CFGW-1:0] m_cfg();
    logic [CFGW-1:0] v;
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 4; i++)
        v[(b*4+i)*16 +: 16] = m_reg[b][i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [CFGW-1:0] got,
                       input logic [CFGW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Configuration bus compared with the model on every idle clock (R4, R9, R10)
  always @(negedge clk) begin
    if (cmp_en && rst_n)
      check(cfg_o === m_cfg(), "R4 cfg bus", cfg_o, m_cfg());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, input string tag);
    logic [23:0] got, exp;
    cmp_en = 1'b0;
    exp = m_pend;
    got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    idle(HALF);
    for (int k = 0; k < nbits; k++) begin
      mosi = w[23-k];
      idle(HALF);
      got[23-k] = miso;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(HALF);
    if (nbits == 24) begin
      check(got === exp, tag, CFGW'(got), CFGW'(exp));
      m_apply(w);
    end
    cmp_en = 1'b1;
  endtask

  task automatic do_reset();
    cmp_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    m_reset();
    idle(4);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired got=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    m_reset();
    idle(5);
    rst_n = 1'b1;
    idle(5);
    cmp_en = 1'b1;
    // R10: idle MISO, then first frame zero
    check(miso === 1'b0, "R10 idle miso", CFGW'(miso), '0);
    xfer(24'h000000, 24, "R10 first frame zero");

    // R5 / R8: read common reg 0x10, drain with nop
    xfer(24'h011001, 24, "R5 request frame");
    xfer(24'h000000, 24, "R5 R8 data next frame");
    xfer(24'h000000, 24, "R6 second nop zero");

    // R4: write common 0x11, read back
    xfer(24'h11BEEF, 24, "R4 write");
    xfer(24'h011101, 24, "R6 after write zero");
    xfer(24'h000000, 24, "R4 readback");

    // R3 / R6 / R7: select voltage bank, pipelined reads
    xfer(24'h020004, 24, "R3 select");
    xfer(24'h011001, 24, "R6 first read after select");
    xfer(24'h011201, 24, "R7 pipeline a");
    xfer(24'h010201, 24, "R7 pipeline b");
    xfer(24'h000000, 24, "R3 R7 select readback");

    // R4: write voltage bank only
    xfer(24'h131234, 24, "R4 bank write");
    xfer(24'h011301, 24, "R4 req");
    xfer(24'h000000, 24, "R4 voltage reg");

    // R3: invalid select code ignored
    xfer(24'h020003, 24, "R3 bad code");
    xfer(24'h010201, 24, "R3 req");
    xfer(24'h000000, 24, "R3 select kept");

    // R9: undefined address write and read
    xfer(24'h20ABCD, 24, "R9 undef write");
    xfer(24'h012001, 24, "R9 req");
    xfer(24'h000000, 24, "R9 undef read zero");

    // R2: aborted frame keeps pending read, writes nothing
    xfer(24'h011201, 24, "R2 req");
    xfer(24'h125555, 12, "R2 aborted");
    xfer(24'h000000, 24, "R2 pending kept");
    xfer(24'h011201, 24, "R2 req again");
    xfer(24'h000000, 24, "R2 no write");

    // R6: opcode 0x01 with wrong tag is not a read
    xfer(24'h011002, 24, "R6 bad tag");
    xfer(24'h000000, 24, "R6 bad tag zero");

    // R3 / R7: current bank
    xfer(24'h020002, 24, "R3 select current");
    xfer(24'h011001, 24, "R6 zero after select");
    xfer(24'h011301, 24, "R7 current a");
    xfer(24'h000000, 24, "R7 current b");

    // R10: reset mid-sequence
    xfer(24'h10FFFF, 24, "R4 pre-reset write");
    xfer(24'h011001, 24, "R10 pending before reset");
    do_reset();
    check(miso === 1'b0, "R10 miso after reset", CFGW'(miso), '0);
    xfer(24'h010201, 24, "R10 pending cleared");
    xfer(24'h011001, 24, "R10 select default");
    xfer(24'h000000, 24, "R10 reg default");

    // R1: alternating bit pattern round-trip
    xfer(24'h115A5A, 24, "R1 write pattern");
    xfer(24'h011101, 24, "R1 req");
    xfer(24'h000000, 24, "R1 pattern out");

    idle(10);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule